// File: doc/BRIEF.md
# Oscillator Band Selection by Counter Race

This block picks the coarse band code of a multi-band oscillator before the surrounding phase-locked loop is allowed to lock. It takes the reference clock and the divided oscillator output, here called the feedback clock. In each round a counter runs in each clock domain, and both are released at the same moment. The counter that first reaches a programmable terminal count shows which clock is faster. The band code then moves one step so that the two frequencies draw closer. While the block runs, the loop keeps its fine tuning voltage parked and its phase comparison switched off. The block handles neither of these; it only produces the code.

A control state machine runs on the system clock. It sends a run level into each counter domain through a two-flop synchronizer. Each counter returns a sticky terminal flag, and that flag is synchronized back into the control domain. Whichever synchronized flag shows up first decides the round. Between rounds both counters are cleared. A new round starts only after both returned flags read low. Calibration stops when the step direction reverses, or after a programmed number of rounds. `term_count` and `max_rounds` must stay stable while `busy` is high.

Top module: `bandcal_top`

## Requirements
- R1: After reset, `band` equals the mid code (2^(BAND_W-1), 16 for the default 5 bits), and `busy` and `done` are low.
- R2: A `start` pulse while idle makes `busy` high and `done` low on the next cycle, and reloads `band` with the mid code.
- R3: When the feedback flag arrives alone (feedback clock faster), `band` rises by one.
- R4: When the reference flag arrives alone (reference clock faster), `band` falls by one.
- R5: `band` saturates. It stays at 0 on a downward step and at 2^BAND_W-1 (31 by default) on an upward step, and it never wraps.
- R6: When both flags become visible in the same control cycle, the round is a tie. `band` is unchanged, and the tie does not count as a direction for reversal.
- R7: When a round's winner calls for the direction opposite to the previous applied step, calibration ends with `band` left at the code in use during that round.
- R8: When the number of completed rounds reaches `max_rounds`, calibration ends with the code produced by the last round.
- R9: `busy` stays high from start until `done` rises. `busy` and `done` are never high together. `done` and `band` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset (control domain; resynchronized into each counter domain) |
| ref_clk | input | 1 | Reference clock |
| fb_clk | input | 1 | Divided oscillator (feedback) clock |
| start | input | 1 | Calibration request, sampled while idle |
| term_count | input | CNT_W | Edges each counter must see to raise its flag |
| max_rounds | input | RND_W | Round limit (0 means 2^RND_W) |
| band | output | BAND_W | Band code to the oscillator |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished, held until the next start |

## Verification
The bench closes the loop with a behavioural oscillator. Its feedback period grows with the band code, and its offsets are chosen so that no band lands exactly on the reference. This makes every race decisive. Two runs converge from opposite sides of the target and must stop on the code just past the crossing. A design that applied the reversing step, or that ignored reversal, would end one code off or would run into the round limit. Two further runs push past the top and bottom codes; a design without saturation would wrap to the far end. A run that uses the same clock for both inputs forces a tie in every round. A design that treats a tie as a win would drift away from 16. A short round limit checks that the block stops on the limit itself and not one round later.

// File: rtl/bandcal_pkg.sv
package bandcal_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2,
        DIR_TIE  = 2'd3
    } dir_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CLEAR = 2'd1,
        S_RACE  = 2'd2
    } state_t;

    // Bit 0 of the flag pair belongs to the feedback counter, bit 1 to the reference counter.
    function automatic dir_t race_dir(input logic [1:0] flags);
        case (flags)
            2'b01:   return DIR_UP;
            2'b10:   return DIR_DN;
            2'b11:   return DIR_TIE;
            default: return DIR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bandcal_sync.sv
module bandcal_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        meta_q <= d;
        stab_q <= meta_q;
    end

    assign q = stab_q;
endmodule

// File: rtl/bandcal_race_ctr.sv
module bandcal_race_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] term_count,
    output logic             hit
);
    logic       rst_s;
    logic       run_s;
    logic [1:0] ctl_s;
    logic [CNT_W-1:0] cnt_q;
    logic             hit_q;

    bandcal_sync #(.WIDTH(2)) u_ctl_sync (
        .clk (clk),
        .d   ({rst, run}),
        .q   (ctl_s)
    );
    assign rst_s = ctl_s[1];
    assign run_s = ctl_s[0];

    // Held at zero while not racing; counts until the terminal edge, then stays flagged.
    always_ff @(posedge clk) begin
        if (rst_s || !run_s) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else if (!hit_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == term_count - 1'b1) hit_q <= 1'b1;
        end
    end

    assign hit = hit_q;

    // R3 / R4: a raised flag stays up until the run level is withdrawn
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst_s)
        (run_s && hit_q) |=> hit_q);

    // R3 / R4: the flag is always cleared together with the counter
    a_r4_flag_clears: assert property (@(posedge clk) disable iff (rst_s)
        (!run_s) |=> (!hit_q && cnt_q == '0));
endmodule

// File: rtl/bandcal_top.sv
module bandcal_top
    import bandcal_pkg::*;
#(
    parameter int BAND_W = 5,
    parameter int CNT_W  = 10,
    parameter int RND_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              fb_clk,
    input  logic              start,
    input  logic [CNT_W-1:0]  term_count,
    input  logic [RND_W-1:0]  max_rounds,
    output logic [BAND_W-1:0] band,
    output logic              busy,
    output logic              done
);
    localparam logic [BAND_W-1:0] BAND_MID = BAND_W'(1) << (BAND_W - 1);
    localparam logic [BAND_W-1:0] BAND_MAX = {BAND_W{1'b1}};
    localparam int NUM_CTR = 2;

    state_t            state_q;
    logic [BAND_W-1:0] band_q;
    logic [BAND_W-1:0] band_next;
    logic [RND_W-1:0]  rounds_q;
    logic [RND_W-1:0]  rounds_n;
    dir_t              last_q;
    dir_t              dir;
    logic              busy_q;
    logic              done_q;
    logic              run_q;
    logic              reversal;

    logic [NUM_CTR-1:0] ctr_clk;
    logic [NUM_CTR-1:0] hit_raw;
    logic [NUM_CTR-1:0] hit_s;

    assign ctr_clk = {ref_clk, fb_clk};

    generate
        for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
            bandcal_race_ctr #(.CNT_W(CNT_W)) u_ctr (
                .clk        (ctr_clk[g]),
                .rst        (rst),
                .run        (run_q),
                .term_count (term_count),
                .hit        (hit_raw[g])
            );
        end
    endgenerate

    bandcal_sync #(.WIDTH(NUM_CTR)) u_hit_sync (
        .clk (clk),
        .d   (hit_raw),
        .q   (hit_s)
    );

    always_comb begin
        dir      = race_dir(hit_s);
        rounds_n = rounds_q + 1'b1;
        reversal = (last_q != DIR_NONE) &&
                   ((dir == DIR_UP && last_q == DIR_DN) || (dir == DIR_DN && last_q == DIR_UP));
        band_next = band_q;
        if (dir == DIR_UP && band_q != BAND_MAX) band_next = band_q + 1'b1;
        if (dir == DIR_DN && band_q != '0)       band_next = band_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            band_q   <= BAND_MID;
            rounds_q <= '0;
            last_q   <= DIR_NONE;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            run_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    run_q <= 1'b0;
                    if (start) begin
                        band_q   <= BAND_MID;
                        rounds_q <= '0;
                        last_q   <= DIR_NONE;
                        busy_q   <= 1'b1;
                        done_q   <= 1'b0;
                        state_q  <= S_CLEAR;
                    end
                end
                S_CLEAR: begin
                    if (hit_s == '0) begin
                        run_q   <= 1'b1;
                        state_q <= S_RACE;
                    end
                end
                S_RACE: begin
                    if (dir != DIR_NONE) begin
                        run_q    <= 1'b0;
                        rounds_q <= rounds_n;
                        if (reversal) begin
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            band_q <= band_next;
                            if (dir != DIR_TIE) last_q <= dir;
                            if (rounds_n == max_rounds) begin
                                busy_q  <= 1'b0;
                                done_q  <= 1'b1;
                                state_q <= S_IDLE;
                            end else begin
                                state_q <= S_CLEAR;
                            end
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign band = band_q;
    assign busy = busy_q;
    assign done = done_q;

    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_q && done_q));

    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && start) |=> (busy_q && !done_q && band_q == BAND_MID));

    a_r5_top_saturates: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RACE && hit_s == 2'b01 && band_q == BAND_MAX) |=> (band_q == BAND_MAX));

    a_r5_bottom_saturates: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RACE && hit_s == 2'b10 && band_q == '0) |=> (band_q == '0));

    a_r6_tie_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RACE && hit_s == 2'b11) |=> $stable(band_q));

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RACE) |=> (band_q == $past(band_q) ||
                                 band_q == $past(band_q) + 1'b1 ||
                                 band_q == $past(band_q) - 1'b1));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && !start) |=> ($stable(band_q) && $stable(done_q)));
endmodule

// File: tb/test_bandcal_top.sv
`timescale 1ns/1ps
module test_bandcal_top;
    localparam int BAND_W = 5;
    localparam int CNT_W  = 10;
    localparam int RND_W  = 6;

    typedef struct packed {
        int ref_ps;
        int base_ps;
        int slope_ps;
        int term;
        int rounds;
        int exp_band;
    } vec_t;

    // Feedback period = base + band*slope; offsets keep every band off the reference.
    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{40000, 20500, 1000, 256, 20, 20},  // R3 R7: climb then reverse
        '{40000, 24500, 1000, 256, 20, 15},  // R4 R7: one step down then reverse
        '{40000,  2500, 1000, 256, 17, 31},  // R5 R8: top saturation
        '{40000, 50500, 1000, 256, 18,  0},  // R5 R8: bottom saturation
        '{40000, 20500, 1000, 256,  2, 18}   // R8: stop on round limit
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk = 1'b0;
    logic nco_clk = 1'b0;
    logic tie_mode = 1'b0;
    logic fb_clk;
    logic start = 1'b0;
    logic [CNT_W-1:0] term_count = CNT_W'(256);
    logic [RND_W-1:0] max_rounds = RND_W'(4);
    logic [BAND_W-1:0] band;
    logic busy;
    logic done;

    real ref_half = 20.0;
    real base_ns  = 20.5;
    real slope_ns = 1.0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;
    always #(ref_half) ref_clk = ~ref_clk;
    always #((base_ns + slope_ns * real'(band)) / 2.0) nco_clk = ~nco_clk;
    assign fb_clk = tie_mode ? ref_clk : nco_clk;

    always @(posedge clk) cycles <= cycles + 1;

    bandcal_top #(.BAND_W(BAND_W), .CNT_W(CNT_W), .RND_W(RND_W)) i_bandcal_top (
        .clk        (clk),
        .rst        (rst),
        .ref_clk    (ref_clk),
        .fb_clk     (fb_clk),
        .start      (start),
        .term_count (term_count),
        .max_rounds (max_rounds),
        .band       (band),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cal(input string tag, input int exp_band);
        int waited;
        logic [BAND_W-1:0] held;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, {"R2 busy after start ", tag}, busy, 1);
        chk(band === 5'd16, {"R2 mid reload ", tag}, band, 16);
        waited = 0;
        while (done !== 1'b1 && waited < 70000) begin
            chk(busy === 1'b1, {"R9 busy while running ", tag}, busy, 1);
            @(negedge clk);
            waited++;
        end
        chk(done === 1'b1, {"R9 finished ", tag}, done, 1);
        chk(band === exp_band[BAND_W-1:0], {"final band ", tag}, band, exp_band);
        chk(busy === 1'b0, {"R9 busy low at done ", tag}, busy, 0);
        held = band;
        repeat (8) @(negedge clk);
        chk(done === 1'b1 && band === held, {"R9 result held ", tag}, band, held);
    endtask

    initial begin
        repeat (100) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(band === 5'd16, "R1 band mid", band, 16);
        chk(busy === 1'b0, "R1 busy low", busy, 0);
        chk(done === 1'b0, "R1 done low", done, 0);

        for (int i = 0; i < NVEC; i++) begin
            ref_half   = real'(VECS[i].ref_ps) / 2000.0;
            base_ns    = real'(VECS[i].base_ps) / 1000.0;
            slope_ns   = real'(VECS[i].slope_ps) / 1000.0;
            term_count = CNT_W'(VECS[i].term);
            max_rounds = RND_W'(VECS[i].rounds);
            run_cal($sformatf("R3 R4 R5 R7 R8 vector %0d", i), VECS[i].exp_band);
        end

        // R6: identical clocks tie every round, so band stays mid until the round limit
        tie_mode   = 1'b1;
        ref_half   = 20.0;
        max_rounds = RND_W'(3);
        run_cal("R6 tie rounds", 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= 195000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule